// File: doc/BRIEF.md
# Link Configuration Register Window

This block is the register file that an endpoint exposes in its configuration space to let a host load the programmable fabric over the link itself. It occupies a 17-word window, byte offsets 0x200 to 0x240. A host reads two identification words and a status word that mirrors the configuration controller's state. It writes a mode/control word and a programming-control word. It streams configuration data one 32-bit word at a time through a data register. Every accepted data write hands the word to the controller together with a programmable number of configuration clock pulses.

Two banks of sticky error flags sit beside the control registers: an uncorrectable bank and a correctable bank. Each has its own mask. A host clears a flag by writing 1 to it. Each bank drives one error line, which is high while any unmasked flag is set. The configuration controller and the clock switching it performs are outside this block. Their status arrives on plain inputs, and their controls leave on registered outputs.

The access port carries a word address, a write strobe and four byte enables. A read returns its data, with a valid flag, one clock after the request.

Top module: `lnkcfg_regwin`

## Requirements
- R1: Offset 0x200 reads 0x0001000B (identifier 0x000B in bits 15:0, version 1 in bits 19:16). Offset 0x204 reads 0x04401172 (identifier 0x1172 in bits 15:0, revision 0 in bits 19:16, length 0x044 in bits 31:20).
- R2: Offset 0x21C reads the status inputs at these bit positions: core ready 25, clock in use 24, configuration done 23, user mode 21, enable 20, configuration error 19, configuration ready 18. All other bits read 0, and writes to this offset have no effect.
- R3: Offset 0x220 holds clocks-per-write in bits 15:8, full-configuration in bit 2, clock-select in bit 1 and mode in bit 0. All of these reset to 0, each byte is written only when its byte enable is set, and the bits drive the matching outputs.
- R4: Writing 1 to the mode bit leaves it 0 while the enable status input is 0.
- R5: A data write to 0x228 with all four byte enables set loads cfg_data. The write data goes to cfg_data[31:0], and the word held at 0x224 is captured at that moment into cfg_data[63:32]. The write then produces exactly clocks-per-write pulses on cfg_clk, each high for one cycle and separated by one low cycle. A count of 0 produces no pulse.
- R6: A data write with any byte enable clear is ignored, and so is a data write that arrives while a pulse burst is still running. Neither changes cfg_data nor starts pulses.
- R7: Offset 0x22C holds start-transfer in bit 1 and configuration-request in bit 0. Both reset to 0 and drive ctl_xfer_start and ctl_cfg_req.
- R8: Offset 0x234 holds uncorrectable flags in bits 11:0. A flag is set by a high on its unc_evt bit and cleared by writing 1 to it. When set and clear coincide, the flag stays set.
- R9: Uncorrectable flag bit 5 is set in any cycle where st_cfg_error is high while the mode bit is 1, and not by st_cfg_error while mode is 0.
- R10: The uncorrectable mask at 0x238 resets to 0xFDF (bit 5 clear, bits 11:0 otherwise set). The correctable mask at 0x240 resets to 0. Both are writable in their implemented bits.
- R11: Offset 0x23C holds correctable flags in bits 6, 5, 1 and 0, set by cor_evt and cleared by writing 1. Bits 4:2 always read 0, and events on them are ignored.
- R12: unc_err is high while any uncorrectable flag is set with its mask bit 0. cor_err behaves the same way for the correctable bank.
- R13: Reads of reserved offsets inside the window (0x208 to 0x218, 0x230) and of any offset outside it return 0. Every read is answered with rsp_valid high one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_waddr | input | 10 | Configuration-space word address (byte offset / 4) |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| st_core_ready | input | 1 | Controller status: core ready |
| st_clk_in_use | input | 1 | Controller status: configuration clock in use |
| st_cfg_done | input | 1 | Controller status: configuration done |
| st_user_mode | input | 1 | Controller status: user mode |
| st_enable | input | 1 | Controller status: link configuration enabled |
| st_cfg_error | input | 1 | Controller status: configuration error |
| st_cfg_ready | input | 1 | Controller status: ready for data |
| unc_evt | input | 12 | Uncorrectable error event pulses |
| cor_evt | input | 7 | Correctable error event pulses |
| ctl_mode | output | 1 | Link configuration mode |
| ctl_clk_sel | output | 1 | Configuration clock select |
| ctl_full_cfg | output | 1 | Full-configuration request |
| ctl_xfer_start | output | 1 | Start transfer |
| ctl_cfg_req | output | 1 | Configuration request |
| cfg_data | output | 64 | Configuration word presented to the controller |
| cfg_clk | output | 1 | Configuration clock pulses |
| unc_err | output | 1 | Unmasked uncorrectable error present |
| cor_err | output | 1 | Unmasked correctable error present |

## Verification
The embedded assertions watch four things on every cycle. The mode bit never rises unless enable was high. Pulses never last longer than one cycle, and a burst always ends on a pulse. A burst starts only after a full-width data write. The sticky flags never drop without a write-one-clear, and every set request lands, including bit 5 raised by a configuration error while in mode. The bench's scenarios are needed for the rest. They confirm the exact pulse count per write, including a count of zero and a write made during a burst. They also cover the byte-lane merging, the reset values of the masks, the masking of the error lines, and the zero returned from reserved and out-of-window offsets.

// File: rtl/lrw_pkg.sv
package lrw_pkg;

  localparam int WIN_WORDS = 17;

  typedef logic [4:0] ofs_t;

  localparam ofs_t OFS_HDR0   = 5'd0;
  localparam ofs_t OFS_HDR1   = 5'd1;
  localparam ofs_t OFS_STAT   = 5'd7;
  localparam ofs_t OFS_MODE   = 5'd8;
  localparam ofs_t OFS_DHI    = 5'd9;
  localparam ofs_t OFS_DLO    = 5'd10;
  localparam ofs_t OFS_PROG   = 5'd11;
  localparam ofs_t OFS_UNC_ST = 5'd13;
  localparam ofs_t OFS_UNC_MK = 5'd14;
  localparam ofs_t OFS_COR_ST = 5'd15;
  localparam ofs_t OFS_COR_MK = 5'd16;

  localparam logic [31:0] HDR0_VAL = 32'h0001_000B;
  localparam logic [31:0] HDR1_VAL = 32'h0440_1172;

  localparam int SB_CORE_RDY = 25;
  localparam int SB_CLK_USE  = 24;
  localparam int SB_CFG_DONE = 23;
  localparam int SB_USER     = 21;
  localparam int SB_ENABLE   = 20;
  localparam int SB_CFG_ERR  = 19;
  localparam int SB_CFG_RDY  = 18;

  localparam int CPW_LSB       = 8;
  localparam int UNC_CFGERR_BIT = 5;

  // expand four byte enables into a 32-bit lane mask
  function automatic logic [31:0] lanes(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

endpackage

// File: rtl/lrw_burst_gen.sv
module lrw_burst_gen #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             pulse_o
);

  logic [LEN_W-1:0] rem_q;
  logic             ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      ph_q  <= 1'b0;
    end else if (start_i && rem_q == '0) begin
      rem_q <= len_i;
      ph_q  <= 1'b0;
    end else if (rem_q != '0) begin
      if (!ph_q) begin
        ph_q <= 1'b1;
      end else begin
        ph_q  <= 1'b0;
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign busy_o  = (rem_q != '0);
  assign pulse_o = ph_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ph_q |=> !ph_q); // R5
  AST_BURST_ENDS_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(ph_q)); // R5

endmodule

// File: rtl/lrw_err_bank.sv
module lrw_err_bank #(
  parameter int           W        = 12,
  parameter logic [W-1:0] IMPL     = '1,
  parameter logic [W-1:0] RST_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mask_we_i,
  input  logic [W-1:0] mask_wd_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         err_o
);

  logic [W-1:0] stat_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] set_eff;

  assign set_eff = set_i & IMPL;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= RST_MASK & IMPL;
    end else begin
      stat_q <= ((stat_q & ~clr_i) | set_eff) & IMPL;
      mask_q <= ((mask_q & ~mask_we_i) | (mask_wd_i & mask_we_i)) & IMPL;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign err_o  = |(stat_q & ~mask_q);

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(set_eff) & stat_q) == $past(set_eff))); // R8
  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i))); // R8

endmodule

// File: rtl/lnkcfg_regwin.sv
module lnkcfg_regwin
  import lrw_pkg::*;
#(
  parameter int                ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE   = 12'h200,
  parameter int                CPW_W  = 8,
  parameter int                UNC_W  = 12,
  parameter int                COR_W  = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-3:0]  req_waddr,
  input  logic [3:0]         req_be,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  input  logic               st_core_ready,
  input  logic               st_clk_in_use,
  input  logic               st_cfg_done,
  input  logic               st_user_mode,
  input  logic               st_enable,
  input  logic               st_cfg_error,
  input  logic               st_cfg_ready,
  input  logic [UNC_W-1:0]   unc_evt,
  input  logic [COR_W-1:0]   cor_evt,
  output logic               ctl_mode,
  output logic               ctl_clk_sel,
  output logic               ctl_full_cfg,
  output logic               ctl_xfer_start,
  output logic               ctl_cfg_req,
  output logic [63:0]        cfg_data,
  output logic               cfg_clk,
  output logic               unc_err,
  output logic               cor_err
);

  localparam int WA = ADDR_W - 2;
  localparam logic [WA-1:0] BASE_W = WA'(BASE >> 2);
  localparam logic [UNC_W-1:0] UNC_RST_MASK = ~(UNC_W'(1) << UNC_CFGERR_BIT);
  localparam logic [COR_W-1:0] COR_IMPL = 7'b110_0011;

  // address decode
  logic [WA-1:0] rel;
  logic          in_win;
  ofs_t          ofs;
  logic          wr_hit;
  logic [31:0]   lane;

  assign rel    = req_waddr - BASE_W;
  assign in_win = (req_waddr >= BASE_W) && (rel < WA'(WIN_WORDS));
  assign ofs    = rel[4:0];
  assign wr_hit = req_valid && req_write && in_win;
  assign lane   = lanes(req_be);

  // control registers
  logic [CPW_W-1:0] cpw_q;
  logic             mode_q, csel_q, full_q;
  logic             xfer_q, creq_q;
  logic [31:0]      dhi_q;
  logic [63:0]      data_q;
  logic             burst_busy;
  logic             dat_go;

  assign dat_go = wr_hit && (ofs == OFS_DLO) && (&req_be) && !burst_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpw_q  <= '0;
      mode_q <= 1'b0;
      csel_q <= 1'b0;
      full_q <= 1'b0;
      xfer_q <= 1'b0;
      creq_q <= 1'b0;
      dhi_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_hit && ofs == OFS_MODE) begin
        if (req_be[0]) begin
          mode_q <= req_wdata[0] & (st_enable | mode_q);
          csel_q <= req_wdata[1];
          full_q <= req_wdata[2];
        end
        if (req_be[1]) cpw_q <= req_wdata[CPW_LSB +: CPW_W];
      end
      if (wr_hit && ofs == OFS_PROG && req_be[0]) begin
        creq_q <= req_wdata[0];
        xfer_q <= req_wdata[1];
      end
      if (wr_hit && ofs == OFS_DHI)
        dhi_q <= (dhi_q & ~lane) | (req_wdata & lane);
      if (dat_go)
        data_q <= {dhi_q, req_wdata};
    end
  end

  // clock burst per accepted data word
  lrw_burst_gen #(.LEN_W(CPW_W)) burst_i (
    .clk    (clk),
    .rst    (rst),
    .start_i(dat_go),
    .len_i  (cpw_q),
    .busy_o (burst_busy),
    .pulse_o(cfg_clk)
  );

  // error banks
  logic [UNC_W-1:0] unc_stat, unc_mask, unc_set;
  logic [COR_W-1:0] cor_stat, cor_mask;
  logic             wr_unc_st, wr_unc_mk, wr_cor_st, wr_cor_mk;

  assign wr_unc_st = wr_hit && (ofs == OFS_UNC_ST);
  assign wr_unc_mk = wr_hit && (ofs == OFS_UNC_MK);
  assign wr_cor_st = wr_hit && (ofs == OFS_COR_ST);
  assign wr_cor_mk = wr_hit && (ofs == OFS_COR_MK);
  assign unc_set   = unc_evt | (UNC_W'(st_cfg_error & mode_q) << UNC_CFGERR_BIT);

  lrw_err_bank #(.W(UNC_W), .IMPL('1), .RST_MASK(UNC_RST_MASK)) unc_bank_i (
    .clk      (clk),
    .rst      (rst),
    .set_i    (unc_set),
    .clr_i    (req_wdata[UNC_W-1:0] & lane[UNC_W-1:0] & {UNC_W{wr_unc_st}}),
    .mask_we_i(lane[UNC_W-1:0] & {UNC_W{wr_unc_mk}}),
    .mask_wd_i(req_wdata[UNC_W-1:0]),
    .stat_o   (unc_stat),
    .mask_o   (unc_mask),
    .err_o    (unc_err)
  );

  lrw_err_bank #(.W(COR_W), .IMPL(COR_IMPL), .RST_MASK('0)) cor_bank_i (
    .clk      (clk),
    .rst      (rst),
    .set_i    (cor_evt),
    .clr_i    (req_wdata[COR_W-1:0] & lane[COR_W-1:0] & {COR_W{wr_cor_st}}),
    .mask_we_i(lane[COR_W-1:0] & {COR_W{wr_cor_mk}}),
    .mask_wd_i(req_wdata[COR_W-1:0]),
    .stat_o   (cor_stat),
    .mask_o   (cor_mask),
    .err_o    (cor_err)
  );

  // read path
  logic [31:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (in_win) begin
      case (ofs)
        OFS_HDR0: rd_word = HDR0_VAL;
        OFS_HDR1: rd_word = HDR1_VAL;
        OFS_STAT: begin
          rd_word[SB_CORE_RDY] = st_core_ready;
          rd_word[SB_CLK_USE]  = st_clk_in_use;
          rd_word[SB_CFG_DONE] = st_cfg_done;
          rd_word[SB_USER]     = st_user_mode;
          rd_word[SB_ENABLE]   = st_enable;
          rd_word[SB_CFG_ERR]  = st_cfg_error;
          rd_word[SB_CFG_RDY]  = st_cfg_ready;
        end
        OFS_MODE: begin
          rd_word[CPW_LSB +: CPW_W] = cpw_q;
          rd_word[2:0] = {full_q, csel_q, mode_q};
        end
        OFS_DHI:    rd_word = dhi_q;
        OFS_PROG:   rd_word[1:0] = {xfer_q, creq_q};
        OFS_UNC_ST: rd_word[UNC_W-1:0] = unc_stat;
        OFS_UNC_MK: rd_word[UNC_W-1:0] = unc_mask;
        OFS_COR_ST: rd_word[COR_W-1:0] = cor_stat;
        OFS_COR_MK: rd_word[COR_W-1:0] = cor_mask;
        default:    rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_word;
    end
  end

  assign ctl_mode       = mode_q;
  assign ctl_clk_sel    = csel_q;
  assign ctl_full_cfg   = full_q;
  assign ctl_xfer_start = xfer_q;
  assign ctl_cfg_req    = creq_q;
  assign cfg_data       = data_q;

  AST_MODE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_mode) |-> $past(st_enable)); // R4
  AST_BURST_FROM_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_busy) |-> $past(req_valid && req_write && req_be == 4'hF)); // R6
  AST_CFGERR_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (st_cfg_error && ctl_mode) |=> unc_stat[UNC_CFGERR_BIT]); // R9

endmodule

// File: tb/lnkcfg_regwin_tb_top.sv
module lnkcfg_regwin_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]  req_waddr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        st_core_ready = 1'b1, st_clk_in_use = 1'b0, st_cfg_done = 1'b1;
  logic        st_user_mode = 1'b0, st_enable = 1'b1, st_cfg_error = 1'b0, st_cfg_ready = 1'b1;
  logic [11:0] unc_evt = '0;
  logic [6:0]  cor_evt = '0;
  logic        ctl_mode, ctl_clk_sel, ctl_full_cfg, ctl_xfer_start, ctl_cfg_req;
  logic [63:0] cfg_data;
  logic        cfg_clk, unc_err, cor_err;

  always #2.5 clk = ~clk;

  lnkcfg_regwin dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_waddr(req_waddr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .st_core_ready(st_core_ready), .st_clk_in_use(st_clk_in_use),
    .st_cfg_done(st_cfg_done), .st_user_mode(st_user_mode), .st_enable(st_enable),
    .st_cfg_error(st_cfg_error), .st_cfg_ready(st_cfg_ready),
    .unc_evt(unc_evt), .cor_evt(cor_evt),
    .ctl_mode(ctl_mode), .ctl_clk_sel(ctl_clk_sel), .ctl_full_cfg(ctl_full_cfg),
    .ctl_xfer_start(ctl_xfer_start), .ctl_cfg_req(ctl_cfg_req),
    .cfg_data(cfg_data), .cfg_clk(cfg_clk), .unc_err(unc_err), .cor_err(cor_err)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // pulse monitor, sampled away from the active edge
  int  pulse_cnt = 0;
  int  dbl_high = 0;
  logic prev_clk = 1'b0;
  always @(negedge clk) begin
    if (cfg_clk && prev_clk) dbl_high++;
    if (cfg_clk) pulse_cnt++;
    prev_clk = cfg_clk;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_waddr = a[11:2]; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_waddr = a[11:2];
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 rsp_valid", {63'd0, rsp_valid}, 64'd1);
    d = rsp_rdata;
  endtask

  // {wr, byte addr, be, wdata, expected read, requirement number}
  localparam int NV = 19;
  localparam logic [84:0] VEC [NV] = '{
    {1'b0, 12'h200, 4'hF, 32'h0, 32'h0001_000B, 4'd1},   // R1
    {1'b0, 12'h204, 4'hF, 32'h0, 32'h0440_1172, 4'd1},   // R1
    {1'b0, 12'h21C, 4'hF, 32'h0, 32'h0294_0000, 4'd2},   // R2
    {1'b1, 12'h21C, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd2},   // R2 write ignored
    {1'b0, 12'h21C, 4'hF, 32'h0, 32'h0294_0000, 4'd2},   // R2
    {1'b0, 12'h220, 4'hF, 32'h0, 32'h0, 4'd3},           // R3 reset
    {1'b1, 12'h220, 4'h2, 32'h0000_0507, 32'h0, 4'd3},   // R3 byte 1 only
    {1'b0, 12'h220, 4'hF, 32'h0, 32'h0000_0500, 4'd3},   // R3
    {1'b1, 12'h220, 4'h1, 32'h0000_FF07, 32'h0, 4'd3},   // R3 byte 0 only
    {1'b0, 12'h220, 4'hF, 32'h0, 32'h0000_0507, 4'd3},   // R3
    {1'b0, 12'h238, 4'hF, 32'h0, 32'h0000_0FDF, 4'd10},  // R10
    {1'b0, 12'h240, 4'hF, 32'h0, 32'h0, 4'd10},          // R10
    {1'b1, 12'h238, 4'h3, 32'hFFFF_0123, 32'h0, 4'd10},  // R10
    {1'b0, 12'h238, 4'hF, 32'h0, 32'h0000_0123, 4'd10},  // R10
    {1'b0, 12'h210, 4'hF, 32'h0, 32'h0, 4'd13},          // R13 reserved
    {1'b0, 12'h230, 4'hF, 32'h0, 32'h0, 4'd13},          // R13 reserved
    {1'b0, 12'h300, 4'hF, 32'h0, 32'h0, 4'd13},          // R13 outside
    {1'b1, 12'h22C, 4'hF, 32'h0000_0003, 32'h0, 4'd7},   // R7
    {1'b0, 12'h22C, 4'hF, 32'h0, 32'h0000_0003, 4'd7}    // R7
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int c0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R3 R7 reset ctl", {59'd0, ctl_mode, ctl_clk_sel, ctl_full_cfg, ctl_xfer_start, ctl_cfg_req}, 64'd0);
    chk("R5 reset data", cfg_data, 64'd0);
    chk("R12 reset err", {62'd0, unc_err, cor_err}, 64'd0);
    chk("R13 reset rsp", {63'd0, rsp_valid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][84]) begin
        wr(VEC[i][83:72], VEC[i][71:68], VEC[i][67:36]);
      end else begin
        rd(VEC[i][83:72], d);
        chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), {32'd0, d}, {32'd0, VEC[i][35:4]});
      end
    end
    chk("R3 R7 ctl outputs", {59'd0, ctl_mode, ctl_clk_sel, ctl_full_cfg, ctl_xfer_start, ctl_cfg_req}, 64'h1F);

    // R4 mode gated by enable
    wr(12'h220, 4'h1, 32'h0);
    st_enable = 1'b0;
    wr(12'h220, 4'h1, 32'h1);
    rd(12'h220, d);
    chk("R4 mode blocked", {32'd0, d}, 64'h500);
    chk("R4 ctl_mode", {63'd0, ctl_mode}, 64'd0);
    st_enable = 1'b1;
    wr(12'h220, 4'h1, 32'h1);
    chk("R4 mode set", {63'd0, ctl_mode}, 64'd1);

    // R5 data word plus five pulses
    wr(12'h224, 4'hF, 32'hA5A5_0001);
    c0 = pulse_cnt;
    wr(12'h228, 4'hF, 32'h1234_5678);
    repeat (14) @(negedge clk);
    chk("R5 pulse count", 64'(pulse_cnt - c0), 64'd5);
    chk("R5 data", cfg_data, 64'hA5A5_0001_1234_5678);
    chk("R5 pulse width", 64'(dbl_high), 64'd0);
    wr(12'h224, 4'hF, 32'hFFFF_FFFF);
    chk("R5 upper captured", cfg_data, 64'hA5A5_0001_1234_5678);

    // R5 zero count
    wr(12'h220, 4'h2, 32'h0);
    c0 = pulse_cnt;
    wr(12'h228, 4'hF, 32'hCAFE_0000);
    repeat (6) @(negedge clk);
    chk("R5 zero pulses", 64'(pulse_cnt - c0), 64'd0);
    chk("R5 zero-count data", cfg_data, 64'hFFFF_FFFF_CAFE_0000);

    // R6 partial byte enables, then write during burst
    wr(12'h220, 4'h2, 32'h0000_0300);
    c0 = pulse_cnt;
    wr(12'h228, 4'h7, 32'h1111_1111);
    repeat (8) @(negedge clk);
    chk("R6 partial be pulses", 64'(pulse_cnt - c0), 64'd0);
    chk("R6 partial be data", cfg_data, 64'hFFFF_FFFF_CAFE_0000);
    c0 = pulse_cnt;
    wr(12'h228, 4'hF, 32'h2222_2222);
    wr(12'h228, 4'hF, 32'h3333_3333);
    repeat (10) @(negedge clk);
    chk("R6 busy pulses", 64'(pulse_cnt - c0), 64'd3);
    chk("R6 busy data", {32'd0, cfg_data[31:0]}, 64'h2222_2222);

    // R8 sticky flags, set wins over clear; mask is 0x123 here
    @(negedge clk); unc_evt = 12'h008;
    @(negedge clk); unc_evt = '0;
    rd(12'h234, d);
    chk("R8 set", {32'd0, d}, 64'h8);
    chk("R12 unc_err unmasked", {63'd0, unc_err}, 64'd1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_waddr = 10'h234 >> 2; req_be = 4'hF;
    req_wdata = 32'h8; unc_evt = 12'h008;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; unc_evt = '0;
    rd(12'h234, d);
    chk("R8 set wins", {32'd0, d}, 64'h8);
    wr(12'h234, 4'hF, 32'h8);
    rd(12'h234, d);
    chk("R8 w1c", {32'd0, d}, 64'h0);
    chk("R12 unc_err cleared", {63'd0, unc_err}, 64'd0);

    // R9 configuration error only counts in mode
    @(negedge clk); st_cfg_error = 1'b1;
    @(negedge clk); st_cfg_error = 1'b0;
    rd(12'h234, d);
    chk("R9 bit5 in mode", {32'd0, d}, 64'h20);
    chk("R12 bit5 masked", {63'd0, unc_err}, 64'd0);
    wr(12'h234, 4'hF, 32'h20);
    wr(12'h220, 4'h1, 32'h0);
    @(negedge clk); st_cfg_error = 1'b1;
    @(negedge clk); st_cfg_error = 1'b0;
    rd(12'h234, d);
    chk("R9 no bit5 out of mode", {32'd0, d}, 64'h0);

    // R11 correctable bank
    @(negedge clk); cor_evt = 7'h7F;
    @(negedge clk); cor_evt = '0;
    rd(12'h23C, d);
    chk("R11 implemented bits", {32'd0, d}, 64'h63);
    chk("R12 cor_err", {63'd0, cor_err}, 64'd1);
    wr(12'h240, 4'hF, 32'hFFFF_FFFF);
    rd(12'h240, d);
    chk("R10 cor mask writable", {32'd0, d}, 64'h63);
    chk("R12 cor_err masked", {63'd0, cor_err}, 64'd0);
    wr(12'h23C, 4'hF, 32'hFF);
    rd(12'h23C, d);
    chk("R11 w1c", {32'd0, d}, 64'h0);

    finish_run();
  end

endmodule